// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block picks one source clock from three candidates and derives two banks of divided clocks from it. The candidates are a fast internal oscillator clock and two redundant reference clocks. A path-select input chooses the oscillator. Otherwise a reference-select input chooses between the two references. Each bank has its own 2-bit ratio select. Bank A offers the even ratios 2, 4, 6 and 8. Bank B offers 4, 6, 8 and 12. Each bank fans its divided clock out to four identical outputs.

A single active-high hold input clears both dividers and takes every output off the bus (high impedance). The hold input is sampled on the selected source clock. After release, both banks begin from a common phase origin, so their first rising edges fall on the same source edge. A registered enable flag shows when the output drivers are active.

A change to a bank's ratio select is applied only when that bank begins a new output period. The period in progress always finishes at its old length, so no runt pulse appears. Source selection is a plain combinational multiplexer. The selects are expected to change only while the hold input is high, with the one exception of the reference select, which may move freely while the oscillator path is chosen.

Top module: `dual_bank_clkdiv`

## Requirements
- R1: Bank A divides the source by 2, 4, 6 or 8 for `div_sel_a` = 0, 1, 2 or 3.
- R2: Bank B divides the source by 4, 6, 8 or 12 for `div_sel_b` = 0, 1, 2 or 3.
- R3: Each divided output has a 50% duty cycle. For ratio N it stays high for N/2 source rising edges, then low for N/2.
- R4: While `hold_rst` is high, both dividers are cleared. From the first source rising edge that samples it high, `drive_en` is 0 and all eight outputs are high impedance.
- R5: Counting source rising edges from the first one that samples `hold_rst` low as edge 1, both banks go high at edge 1. Bank X, with half-ratio h, is high at edge k exactly when floor((k-1)/h) is even.
- R6: With `use_osc` = 1 the source is `osc_clk`. With `use_osc` = 0 the source is one of the reference clocks.
- R7: With `use_osc` = 0, `ref_pick` = 0 selects `ref0_clk` and 1 selects `ref1_clk`. While `use_osc` = 1, `ref_pick` has no effect on the outputs.
- R8: The four outputs of a bank always carry the same value.
- R9: A ratio-select change made during a period is applied at that bank's next period start, which is the edge where the output rises. The current period finishes with the old ratio.
- R10: `drive_en` rises on the first source rising edge that samples `hold_rst` low. The outputs are driven from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Fast internal oscillator clock |
| ref0_clk | input | 1 | Reference clock 0 |
| ref1_clk | input | 1 | Reference clock 1 |
| use_osc | input | 1 | 1: oscillator is the source; 0: a reference is the source |
| ref_pick | input | 1 | Reference choice: 0 = ref0_clk, 1 = ref1_clk |
| hold_rst | input | 1 | Synchronous active-high divider clear and output disable |
| div_sel_a | input | 2 | Bank A ratio select |
| div_sel_b | input | 2 | Bank B ratio select |
| bank_a_q | output | 4 | Bank A divided clocks, high impedance when disabled |
| bank_b_q | output | 4 | Bank B divided clocks, high impedance when disabled |
| drive_en | output | 1 | Registered flag, 1 while the outputs are driven |

## Verification
A corrupt half-period counter or a stale latched ratio shows up at the ports within one output period. It appears as an edge that comes early or late relative to the arithmetic edge pattern, which is at most 12 source edges. A wrong source choice shifts every output edge away from the clock the bench is stepping on. Because the banks share a phase origin, it is visible from the first period after release. A ratio latched at the wrong moment shortens or stretches the period that straddles the select change, and the mid-period change sequence is aimed at exactly that period.

// File: rtl/dbdiv_pkg.sv
package dbdiv_pkg;
  localparam int SEL_W     = 2;
  localparam int SEL_CODES = 1 << SEL_W;
  typedef logic [SEL_W-1:0] ratio_sel_t;
endpackage

// File: rtl/dbdiv_src_mux.sv
module dbdiv_src_mux (
  input  logic osc_clk,
  input  logic ref0_clk,
  input  logic ref1_clk,
  input  logic use_osc,
  input  logic ref_pick,
  output logic src_clk
);
  logic ref_clk;

  always_comb begin
    ref_clk = ref_pick ? ref1_clk : ref0_clk;
    src_clk = use_osc ? osc_clk : ref_clk;
  end
endmodule

// File: rtl/dbdiv_enable.sv
module dbdiv_enable (
  input  logic clk,
  input  logic rst,
  output logic oe_q
);
  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= 1'b1;
  end
endmodule

// File: rtl/dbdiv_bank.sv
module dbdiv_bank
  import dbdiv_pkg::*;
#(
  parameter int RATIO_W = 8,
  parameter logic [SEL_CODES-1:0][RATIO_W-1:0] RATIOS = {RATIO_W'(8), RATIO_W'(6), RATIO_W'(4), RATIO_W'(2)}
) (
  input  logic               clk,
  input  logic               rst,
  input  ratio_sel_t         sel,
  output logic               div_o,
  output logic [RATIO_W-1:0] half_o
);
  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] half_q;
  logic [RATIO_W-1:0] half_sel;
  logic [RATIO_W-1:0] eff_half;
  logic               div_q;
  logic               period_start;
  logic               wrap;

  always_comb begin
    half_sel     = RATIOS[sel] >> 1;
    period_start = (cnt_q == '0) && !div_q;
    eff_half     = period_start ? half_sel : half_q;
    wrap         = (cnt_q == eff_half - ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      div_q  <= 1'b0;
      half_q <= half_sel;
    end else begin
      if (period_start) half_q <= half_sel;
      if (cnt_q == '0)  div_q  <= ~div_q;
      cnt_q <= wrap ? '0 : cnt_q + ONE;
    end
  end

  assign div_o  = div_q;
  assign half_o = half_q;
endmodule

// File: rtl/dual_bank_clkdiv.sv
module dual_bank_clkdiv
  import dbdiv_pkg::*;
#(
  parameter int OUTS_PER_BANK = 4,
  parameter int RATIO_W       = 8,
  parameter logic [SEL_CODES-1:0][RATIO_W-1:0] RATIOS_A = {RATIO_W'(8), RATIO_W'(6), RATIO_W'(4), RATIO_W'(2)},
  parameter logic [SEL_CODES-1:0][RATIO_W-1:0] RATIOS_B = {RATIO_W'(12), RATIO_W'(8), RATIO_W'(6), RATIO_W'(4)}
) (
  input  logic                     osc_clk,
  input  logic                     ref0_clk,
  input  logic                     ref1_clk,
  input  logic                     use_osc,
  input  logic                     ref_pick,
  input  logic                     hold_rst,
  input  logic [SEL_W-1:0]         div_sel_a,
  input  logic [SEL_W-1:0]         div_sel_b,
  output logic [OUTS_PER_BANK-1:0] bank_a_q,
  output logic [OUTS_PER_BANK-1:0] bank_b_q,
  output logic                     drive_en
);
  logic               src_clk;
  logic               oe_q;
  logic               div_a;
  logic               div_b;
  logic [RATIO_W-1:0] half_a;
  logic [RATIO_W-1:0] half_b;

  dbdiv_src_mux u_mux (
    .osc_clk  (osc_clk),
    .ref0_clk (ref0_clk),
    .ref1_clk (ref1_clk),
    .use_osc  (use_osc),
    .ref_pick (ref_pick),
    .src_clk  (src_clk)
  );

  dbdiv_enable u_en (
    .clk  (src_clk),
    .rst  (hold_rst),
    .oe_q (oe_q)
  );

  dbdiv_bank #(.RATIO_W(RATIO_W), .RATIOS(RATIOS_A)) u_bank_a (
    .clk    (src_clk),
    .rst    (hold_rst),
    .sel    (div_sel_a),
    .div_o  (div_a),
    .half_o (half_a)
  );

  dbdiv_bank #(.RATIO_W(RATIO_W), .RATIOS(RATIOS_B)) u_bank_b (
    .clk    (src_clk),
    .rst    (hold_rst),
    .sel    (div_sel_b),
    .div_o  (div_b),
    .half_o (half_b)
  );

  for (genvar i = 0; i < OUTS_PER_BANK; i++) begin : g_pad
    assign bank_a_q[i] = oe_q ? div_a : 1'bz;
    assign bank_b_q[i] = oe_q ? div_b : 1'bz;
  end

  assign drive_en = oe_q;
endmodule

// File: rtl/dbdiv_checker.sv
module dbdiv_checker #(
  parameter int OUTS    = 4,
  parameter int RATIO_W = 8
) (
  input logic               src_clk,
  input logic               hold_rst,
  input logic               oe_q,
  input logic               div_a,
  input logic               div_b,
  input logic [RATIO_W-1:0] half_a,
  input logic [RATIO_W-1:0] half_b,
  input logic [OUTS-1:0]    qa,
  input logic [OUTS-1:0]    qb
);
  logic               last_a, last_b;
  logic               primed_a, primed_b;
  logic [RATIO_W-1:0] run_a, run_b;

  always_ff @(posedge src_clk) begin
    if (hold_rst) begin
      last_a <= 1'b0; last_b <= 1'b0;
      primed_a <= 1'b0; primed_b <= 1'b0;
      run_a <= '0; run_b <= '0;
    end else begin
      last_a <= div_a;
      last_b <= div_b;
      if (div_a != last_a) begin primed_a <= 1'b1; run_a <= RATIO_W'(1); end
      else run_a <= run_a + RATIO_W'(1);
      if (div_b != last_b) begin primed_b <= 1'b1; run_b <= RATIO_W'(1); end
      else run_b <= run_b + RATIO_W'(1);
    end
  end

  // R3
  duty_a_chk: assert property (@(posedge src_clk) disable iff (hold_rst)
    (div_a != last_a) && primed_a |-> run_a == $past(half_a));

  // R3
  duty_b_chk: assert property (@(posedge src_clk) disable iff (hold_rst)
    (div_b != last_b) && primed_b |-> run_b == $past(half_b));

  // R5
  align_chk: assert property (@(posedge src_clk) disable iff (hold_rst)
    $fell(hold_rst) |=> (div_a && div_b));

  // R10
  enable_rise_chk: assert property (@(posedge src_clk) disable iff (hold_rst)
    !hold_rst |=> oe_q);

  // R4
  enable_drop_chk: assert property (@(posedge src_clk)
    hold_rst |=> !oe_q);

  // R8
  fanout_equal_chk: assert property (@(posedge src_clk) disable iff (hold_rst)
    oe_q |-> (qa == {OUTS{qa[0]}}) && (qb == {OUTS{qb[0]}}));
endmodule

bind dual_bank_clkdiv dbdiv_checker #(.OUTS(OUTS_PER_BANK), .RATIO_W(RATIO_W)) u_chk (
  .src_clk  (src_clk),
  .hold_rst (hold_rst),
  .oe_q     (oe_q),
  .div_a    (div_a),
  .div_b    (div_b),
  .half_a   (half_a),
  .half_b   (half_b),
  .qa       (bank_a_q),
  .qb       (bank_b_q)
);

// File: tb/tb_dual_bank_clkdiv.sv
`timescale 1ns/1ps
module tb_dual_bank_clkdiv;
  logic osc_clk = 1'b0, ref0_clk = 1'b0, ref1_clk = 1'b0;
  logic use_osc = 1'b1, ref_pick = 1'b0, hold_rst = 1'b1;
  logic [1:0] sel_a = 2'd0, sel_b = 2'd0;
  wire  [3:0] qa, qb;
  wire        drive_en;
  int n_vec = 0, n_bad = 0;
  int ra[4] = '{2, 4, 6, 8};
  int rb[4] = '{4, 6, 8, 12};

  always #2.5 osc_clk  = ~osc_clk;
  always #7   ref0_clk = ~ref0_clk;
  always #11  ref1_clk = ~ref1_clk;

  dual_bank_clkdiv dut (
    .osc_clk(osc_clk), .ref0_clk(ref0_clk), .ref1_clk(ref1_clk),
    .use_osc(use_osc), .ref_pick(ref_pick), .hold_rst(hold_rst),
    .div_sel_a(sel_a), .div_sel_b(sel_b),
    .bank_a_q(qa), .bank_b_q(qb), .drive_en(drive_en)
  );

  task automatic step(int s);
    case (s)
      0:       @(posedge osc_clk);
      1:       @(posedge ref0_clk);
      default: @(posedge ref1_clk);
    endcase
    #1;
  endtask

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] pat(int k, int h);
    return (((k - 1) / h) % 2 == 0) ? 4'hF : 4'h0;
  endfunction

  // s: 0 = oscillator, 1 = reference 0, 2 = reference 1
  task automatic configure(int s, int sa, int sb);
    @(posedge osc_clk); #1;
    hold_rst = 1'b1;
    use_osc  = (s == 0);
    ref_pick = (s == 2);
    sel_a    = 2'(sa);
    sel_b    = 2'(sb);
    repeat (3) step(s);
    check("R4 drive_en while held", {3'b0, drive_en}, 4'h0);
    hold_rst = 1'b0;
  endtask

  initial begin
    // Exhaustive sweep: every source, every ratio pair
    for (int s = 0; s < 3; s++)
      for (int sa = 0; sa < 4; sa++)
        for (int sb = 0; sb < 4; sb++) begin
          configure(s, sa, sb);
          for (int k = 1; k <= 26; k++) begin
            step(s);
            if (k == 1) check("R10 drive_en after release", {3'b0, drive_en}, 4'h1);
            check($sformatf("R1 R3 R5 R6 R7 R8 bank A s=%0d sel=%0d k=%0d", s, sa, k), qa, pat(k, ra[sa] / 2));
            check($sformatf("R2 R3 R5 R6 R7 R8 bank B s=%0d sel=%0d k=%0d", s, sb, k), qb, pat(k, rb[sb] / 2));
          end
        end

    // R7: reference choice ignored on the oscillator path
    configure(0, 1, 1);
    for (int k = 1; k <= 20; k++) begin
      step(0);
      check($sformatf("R7 ref_pick ignored A k=%0d", k), qa, pat(k, 2));
      check($sformatf("R7 ref_pick ignored B k=%0d", k), qb, pat(k, 3));
      if (k == 6) ref_pick = 1'b1;
    end

    // R9: mid-period change of bank A ratio from 4 to 8
    configure(1, 1, 0);
    for (int k = 1; k <= 16; k++) begin
      step(1);
      check($sformatf("R9 bank A after change k=%0d", k), qa,
            (k <= 4) ? pat(k, 2) : pat(k - 4, 4));
      check($sformatf("R9 bank B unaffected k=%0d", k), qb, pat(k, 2));
      if (k == 2) sel_a = 2'd3;
    end

    // R4: hold asserted mid-run disables on the next source edge
    hold_rst = 1'b1;
    step(1);
    check("R4 drive_en drops mid-run", {3'b0, drive_en}, 4'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge osc_clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule